// File: doc/BRIEF.md
# Interrupt Status, Mask and Acknowledge Unit

This block collects one-cycle event pulses from the transmit and receive datapaths, together with level-type cause lines from several sub-units, into one 32-bit interrupt status word. From that word it produces a single maskable interrupt line for the CPU. A second output flags the pending causes that count as abnormal. Software reaches the block through a small register port that has four word addresses. These give a status view that clears on read, an alias view that does not clear, a mask register, and a write-one-to-clear acknowledge register.

The status word holds three kinds of content. The low field has sticky event flags. The middle field has live copies of the sub-unit cause levels; those causes are cleared at their own sub-unit, never here. The top 13 bits hold the transmit completion index, so an interrupt handler can see transmit progress without a second access.

Top module: `irq_status_unit`

## Requirements
- R1: A one-cycle pulse on `ev_pulse[i]` for i in {0,1,2,4,5,6} sets status bit i at the next rising edge. The bit then stays set until it is cleared.
- R2: A read of address 0 returns the status word on `reg_rdata` after the edge that samples `reg_rd`. At that same edge it clears status bits 0 to 6.
- R3: A read of address 1 returns the same word as address 0 and clears nothing.
- R4: Status bits 13 to 18 equal `src_level[5:0]` at all times. Reads and acknowledge writes never clear them.
- R5: Status bits 31 to 19 equal `tx_done_idx[12:0]`.
- R6: Address 2 is the mask register. It is writable and readable only at cause positions 0-2, 4-6 and 13-18 (bit pattern 0x0007E077). All other bits read 0, and the register resets to 0.
- R7: `cpu_irq` is a register. It goes high one edge after any status bit in 0 to 18 is set while its mask bit is 0, and low one edge after no such bit remains. The index field never raises it.
- R8: At address 3, writing 1 to any of bits 0 to 6 clears that status bit. A written 0 leaves the bit unchanged, bits above 6 are ignored, and a read of address 3 returns 0.
- R9: If an event pulse arrives in the same cycle as a clearing read or an acknowledge write for its bit, the bit ends up set.
- R10: Status bits 3 and 7 to 12 always read 0. A pulse on `ev_pulse[3]` has no effect on the status word or on `cpu_irq`.
- R11: `cpu_abn` is a register that follows the rule of R7, restricted to the abnormal causes: bits 5, 6 and 13 to 18.
- R12: After reset the event flags and the mask are 0, and `cpu_irq` and `cpu_abn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 7 | Event pulses for status bits 0 to 6 (bit 3 unused) |
| src_level | input | 6 | Sub-unit cause levels for status bits 13 to 18 |
| tx_done_idx | input | 13 | Transmit completion ring index |
| reg_addr | input | 2 | Word select: 0 status, 1 alias, 2 mask, 3 acknowledge |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Maskable interrupt to the CPU |
| cpu_abn | output | 1 | Unmasked abnormal cause pending |

## Verification
Each result has a fixed latency. A pulse shows in the status word one edge after it is driven. `cpu_irq` and `cpu_abn` follow one edge after that. Read data and the read-side clear both land on the edge that samples the read strobe, and a mask or acknowledge write takes effect at its own edge. The bench drives every input one nanosecond after a rising edge and checks the interrupt lines at that point, after counting the edges needed. Reads go to a queue of expected words, and a monitor compares them at the falling edge that follows the capturing edge. Collision cases drive a pulse and a clear in the same cycle, then read through the alias to see which one won.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ALIAS  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_ACK    = 2'd3
  } reg_sel_e;

  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_EVT_W  = 7;
  localparam int unsigned DEF_SRC_W  = 6;
  localparam int unsigned DEF_IDX_W  = 13;
  localparam int unsigned DEF_SRC_LSB = 13;

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int unsigned EVT_W = 7,
  parameter logic [EVT_W-1:0] IMPL = 7'b1110111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] ev_pulse,
  input  logic             rd_clr,
  input  logic             ack_wr,
  input  logic [EVT_W-1:0] ack_bits,
  output logic [EVT_W-1:0] evt_q
);

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      logic clr_req;
      logic bit_d;
      logic bit_q;

      always_comb begin
        clr_req = rd_clr | (ack_wr & ack_bits[i]);
        bit_d   = bit_q;
        if (ev_pulse[i]) begin
          bit_d = 1'b1;
        end else if (clr_req) begin
          bit_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else begin
          bit_q <= bit_d;
        end
      end

      assign evt_q[i] = bit_q;

      // R1
      evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[i] |=> evt_q[i]);
      // R2
      rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev_pulse[i]) |=> !evt_q[i]);
      // R8
      ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[i] && !rd_clr && !(ack_wr && ack_bits[i])) |=> evt_q[i]);
      // R8
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && ack_bits[i] && !ev_pulse[i]) |=> !evt_q[i]);
    end else begin : g_none
      assign evt_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] WMASK = 32'h0007_E077
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q
);

  logic [DATA_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      mask_d = wdata & WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q == ($past(wdata) & WMASK)));
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] CAUSE = 32'h0007_E077,
  parameter logic [DATA_W-1:0] ABN   = 32'h0007_E060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status_w,
  input  logic [DATA_W-1:0] mask_q,
  output logic              cpu_irq,
  output logic              cpu_abn
);

  logic [DATA_W-1:0] live;
  logic              irq_d;
  logic              abn_d;

  always_comb begin
    live  = status_w & ~mask_q;
    irq_d = |(live & CAUSE);
    abn_d = |(live & ABN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      cpu_abn <= 1'b0;
    end else begin
      cpu_irq <= irq_d;
      cpu_abn <= abn_d;
    end
  end

  // R11
  abn_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_abn |-> cpu_irq);

endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] status_w,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      unique case (sel)
        SEL_STATUS, SEL_ALIAS: rdata_d = status_w;
        SEL_MASK:              rdata_d = mask_q;
        default:               rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned EVT_W   = DEF_EVT_W,
  parameter int unsigned SRC_W   = DEF_SRC_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned SRC_LSB = DEF_SRC_LSB,
  parameter logic [EVT_W-1:0] EVT_IMPL = 7'b1110111,
  parameter logic [EVT_W-1:0] EVT_ABN  = 7'b1100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  ev_pulse,
  input  logic [SRC_W-1:0]  src_level,
  input  logic [IDX_W-1:0]  tx_done_idx,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_irq,
  output logic              cpu_abn
);

  localparam int unsigned IDX_LSB = DATA_W - IDX_W;
  localparam logic [DATA_W-1:0] SRC_FIELD = DATA_W'({SRC_W{1'b1}}) << SRC_LSB;
  localparam logic [DATA_W-1:0] IDX_FIELD = DATA_W'({IDX_W{1'b1}}) << IDX_LSB;
  localparam logic [DATA_W-1:0] CAUSE_MASK = DATA_W'(EVT_IMPL) | SRC_FIELD;
  localparam logic [DATA_W-1:0] ABN_MASK   = DATA_W'(EVT_ABN) | SRC_FIELD;
  localparam logic [DATA_W-1:0] ZERO_MASK  = ~(CAUSE_MASK | IDX_FIELD);

  reg_sel_e          sel;
  logic              rd_clr;
  logic              ack_wr;
  logic              mask_wr;
  logic [EVT_W-1:0]  evt_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_w;

  always_comb begin
    sel     = reg_sel_e'(reg_addr);
    rd_clr  = reg_rd && (sel == SEL_STATUS);
    ack_wr  = reg_wr && (sel == SEL_ACK);
    mask_wr = reg_wr && (sel == SEL_MASK);
  end

  always_comb begin
    status_w = '0;
    status_w[EVT_W-1:0]          = evt_q;
    status_w[SRC_LSB +: SRC_W]   = src_level;
    status_w[IDX_LSB +: IDX_W]   = tx_done_idx;
  end

  irq_evt_latch #(
    .EVT_W (EVT_W),
    .IMPL  (EVT_IMPL)
  ) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_pulse (ev_pulse),
    .rd_clr   (rd_clr),
    .ack_wr   (ack_wr),
    .ack_bits (reg_wdata[EVT_W-1:0]),
    .evt_q    (evt_q)
  );

  irq_mask_reg #(
    .DATA_W (DATA_W),
    .WMASK  (CAUSE_MASK)
  ) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (reg_wdata),
    .mask_q (mask_q)
  );

  irq_gen #(
    .DATA_W (DATA_W),
    .CAUSE  (CAUSE_MASK),
    .ABN    (ABN_MASK)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_w (status_w),
    .mask_q   (mask_q),
    .cpu_irq  (cpu_irq),
    .cpu_abn  (cpu_abn)
  );

  irq_rd_port #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (reg_rd),
    .sel      (sel),
    .status_w (status_w),
    .mask_q   (mask_q),
    .rdata    (reg_rdata)
  );

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_w & ~mask_q & CAUSE_MASK)) |=> cpu_irq);
  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_w & ~mask_q & CAUSE_MASK)) |=> !cpu_irq);
  // R3
  alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == SEL_ALIAS) |=> (reg_rdata == $past(status_w)));
  // R3
  alias_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == SEL_ALIAS && !reg_wr) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ZERO_MASK) == '0);

endmodule

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [6:0]  ev_pulse;
  logic [5:0]  src_level;
  logic [12:0] tx_done_idx;
  logic [1:0]  reg_addr;
  logic        reg_rd;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cpu_irq;
  logic        cpu_abn;

  int n_chk;
  int n_fail;
  bit done;
  logic rd_seen;

  string       tag_q[$];
  logic [31:0] val_q[$];

  irq_status_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_pulse    (ev_pulse),
    .src_level   (src_level),
    .tx_done_idx (tx_done_idx),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cpu_irq     (cpu_irq),
    .cpu_abn     (cpu_abn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: pops one expected word per captured read
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (val_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: read with no expected item, actual %08h", reg_rdata);
      end else begin
        string t;
        logic [31:0] v;
        t = tag_q.pop_front();
        v = val_q.pop_front();
        n_chk++;
        if (reg_rdata !== v) begin
          n_fail++;
          $display("FAIL %s: rdata actual %08h expected %08h", t, reg_rdata, v);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_read(input logic [1:0] a, input logic [31:0] exp, input string t);
    reg_addr = a; reg_rd = 1'b1;
    tag_q.push_back(t); val_q.push_back(exp);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [6:0] p);
    ev_pulse = p;
    tick();
    ev_pulse = '0;
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; ev_pulse = '0; src_level = '0; tx_done_idx = '0;
    reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R12 reset state
    chk_bit(cpu_irq, 1'b0, "R12 irq after reset");
    chk_bit(cpu_abn, 1'b0, "R12 abn after reset");
    do_read(2'd0, 32'h0, "R12 status after reset");
    do_read(2'd2, 32'h0, "R12 mask after reset");

    // R1 / R7 latency
    pulse(7'h01);
    chk_bit(cpu_irq, 1'b0, "R7 irq not yet one edge after pulse");
    tick();
    chk_bit(cpu_irq, 1'b1, "R7 irq two edges after pulse");
    do_read(2'd1, 32'h1, "R3 alias first read");
    do_read(2'd1, 32'h1, "R3 alias second read keeps bit");
    do_read(2'd0, 32'h1, "R2 status read returns bit");
    do_read(2'd0, 32'h0, "R2 status read cleared bit");
    tick();
    chk_bit(cpu_irq, 1'b0, "R7 irq drops after clear");

    // R10 bit 3 ignored
    pulse(7'h08);
    tick();
    do_read(2'd1, 32'h0, "R10 pulse on bit3 ignored");
    chk_bit(cpu_irq, 1'b0, "R10 irq unaffected by bit3");

    // R1 / R8 acknowledge
    pulse(7'h7F);
    do_read(2'd1, 32'h77, "R1 all event bits set");
    do_write(2'd3, 32'h0);
    do_read(2'd1, 32'h77, "R8 zero write has no effect");
    do_write(2'd3, 32'hFFFF_FF85);
    do_read(2'd1, 32'h72, "R8 ones clear bits 0 and 2 only");
    do_read(2'd3, 32'h0, "R8 ack address reads zero");
    do_write(2'd3, 32'h72);
    do_read(2'd1, 32'h0, "R8 remaining bits cleared");

    // R4 level causes
    src_level = 6'b000001;
    tick();
    do_read(2'd1, 32'h2000, "R4 level cause visible");
    do_read(2'd0, 32'h2000, "R4 status read");
    do_write(2'd3, 32'hFFFF_FFFF);
    do_read(2'd1, 32'h2000, "R4 survives read and ack");
    chk_bit(cpu_irq, 1'b1, "R7 irq from level cause");
    chk_bit(cpu_abn, 1'b1, "R11 abn from level cause");
    src_level = 6'b100000;
    tick();
    do_read(2'd1, 32'h0004_0000, "R4 top level cause bit18");
    src_level = '0;
    tick();
    tick();
    do_read(2'd1, 32'h0, "R4 cause follows level drop");
    chk_bit(cpu_irq, 1'b0, "R7 irq drops with level");

    // R5 completion index
    tx_done_idx = 13'h1ABC;
    do_read(2'd0, 32'hD5E0_0000, "R5 index in top bits");
    tick();
    chk_bit(cpu_irq, 1'b0, "R7 index never raises irq");
    tx_done_idx = '0;

    // R6 mask
    do_write(2'd2, 32'hFFFF_FFFF);
    do_read(2'd2, 32'h0007_E077, "R6 mask implemented bits");
    pulse(7'h02);
    tick();
    chk_bit(cpu_irq, 1'b0, "R6 masked cause blocks irq");
    do_write(2'd2, 32'hFFFF_FFFD);
    tick();
    chk_bit(cpu_irq, 1'b1, "R6 unmasked cause raises irq");
    chk_bit(cpu_abn, 1'b0, "R11 bit1 is not abnormal");
    do_read(2'd0, 32'h2, "R2 clear masked event");
    do_write(2'd2, 32'h0);

    // R11 abnormal
    pulse(7'h20);
    tick();
    chk_bit(cpu_abn, 1'b1, "R11 abn from bit5");
    do_write(2'd2, 32'h20);
    tick();
    chk_bit(cpu_abn, 1'b0, "R11 abn masked");
    do_write(2'd2, 32'h0);
    do_write(2'd3, 32'h20);
    tick();
    chk_bit(cpu_abn, 1'b0, "R11 abn after ack");

    // R9 collisions
    ev_pulse = 7'h10; reg_addr = 2'd0; reg_rd = 1'b1;
    tag_q.push_back("R9 read during pulse returns old word"); val_q.push_back(32'h0);
    tick();
    ev_pulse = '0; reg_rd = 1'b0;
    do_read(2'd1, 32'h10, "R9 event wins over clearing read");
    ev_pulse = 7'h10; reg_addr = 2'd3; reg_wdata = 32'h10; reg_wr = 1'b1;
    tick();
    ev_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    do_read(2'd1, 32'h10, "R9 event wins over ack");
    do_write(2'd3, 32'h10);
    do_read(2'd1, 32'h0, "R8 final ack clears");

    tick();
    tick();
    if (val_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d items left expected 0", val_q.size());
    end
    finish_run();
  end

endmodule